// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block connects a CPU-side data-memory request port to an external 8-bit SRAM over a narrow pin set. The low address byte and the data byte share one bidirectional 8-bit bus. An address-latch strobe captures the low byte into an external latch, and the upper address bits appear on a separate high-address bus. Read and write are signalled by two active-low strobes. Each request is classified by address. At or below the internal boundary it goes to internal memory and completes in one cycle. Above the boundary it runs an external cycle while the interface is enabled, and it is reported as unmapped while the interface is disabled.

An external cycle has three parts. First comes an address phase with the latch strobe high. Next is one hold cycle in which the latch strobe is low and the address is still driven. Last is a strobe phase of one cycle plus the configured wait states, followed by a closing cycle in which the ready pulse is returned. While the interface is enabled it owns the direction and output value of its pins, including the selected number of high-address pins. When it is disabled, every pin follows the normal port settings supplied by the surrounding logic.

Top module: `xbus_ctrl`

## Requirements
- R1: During and right after reset, both strobes are high, the latch strobe is low, the shared bus is not driven and no ready pulse is given.
- R2: For an external access, the latch strobe is high for exactly one cycle starting the cycle after the request. In that cycle the low address byte is driven on the shared bus and the upper bits are on the high bus. In the next cycle the latch strobe is low and the same address byte is still driven.
- R3: An external read releases the shared bus and holds the read strobe low for 1+W cycles, where W is the wait-state count. The bus is sampled on the last strobe cycle. Ready, carrying that byte, is high in the cycle when the strobe returns high, which is 4+W cycles after the request cycle.
- R4: An external write drives the write data from the first strobe cycle and holds the write strobe low for 1+W cycles. The data stays driven for one cycle after the strobe rises, and ready is high in that cycle, 4+W cycles after the request.
- R5: The latch strobe is low during the whole strobe phase, and a strobe is only ever low while the latch strobe is low.
- R6: An address at or below the internal boundary (default 0x10FF) raises the internal-select output in the request cycle. Ready follows in the next cycle with the internal read byte, and neither strobe goes low. While the interface is enabled, the latch strobe is high and the address byte is driven in that cycle.
- R7: While the interface is disabled, an address above the boundary does not raise the internal-select output and does not toggle any strobe. Ready follows in the next cycle with the error flag set and read data 0x00.
- R8: Pin control bit 0 is the latch strobe, bit 1 the read strobe and bit 2 the write strobe. While the interface is enabled, all three control pins and the shared bus take their direction and value from the controller, and high pins 0 to N-1 are driven with the address, where N is the configured high-pin count. All other pins, and every pin while the interface is disabled, take the port settings.
- R9: The two strobes are never low together. A request that arrives while an access is in progress is ignored: it raises no internal select and produces no extra ready pulse.
- R10: The wait-state count is captured when a request is accepted. A change to it during an access does not alter that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Interface enable |
| cfg_wait | input | WAIT_W | Wait states added to the strobe phase |
| cfg_hi_n | input | HCW | Number of high-address pins taken over |
| req | input | 1 | Single-cycle access request |
| req_addr | input | ADDR_W | Access address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rdy | output | 1 | Completion pulse |
| rsp_err | output | 1 | Unmapped access flag, valid with rdy |
| rdata | output | 8 | Read byte, valid with rdy |
| int_req | output | 1 | Internal memory select (request cycle) |
| int_we | output | 1 | Internal write enable (request cycle) |
| int_rdata | input | 8 | Internal memory read byte, valid the cycle after int_req |
| ad_in | input | 8 | Shared bus input value |
| pin_lo_out | output | 8 | Shared bus output value |
| pin_lo_oe | output | 1 | Shared bus output enable |
| pin_hi_out | output | ADDR_W-8 | High address pin values |
| pin_hi_oe | output | ADDR_W-8 | High address pin enables |
| pin_ctl_out | output | 3 | {write strobe, read strobe, latch strobe} |
| pin_ctl_oe | output | 3 | Control pin enables |
| port_lo_out | input | 8 | Port value for the shared bus |
| port_lo_oe | input | 1 | Port enable for the shared bus |
| port_hi_out | input | ADDR_W-8 | Port values for the high pins |
| port_hi_oe | input | ADDR_W-8 | Port enables for the high pins |
| port_ctl_out | input | 3 | Port values for the control pins |
| port_ctl_oe | input | 3 | Port enables for the control pins |

## Verification
The embedded assertions check the following on every cycle: the two strobes are never low together, a strobe is low only while the latch strobe is low, the bus is released during a read strobe, the address is held for one cycle after the latch strobe falls, write data is held as the write strobe rises, internal and unmapped requests complete in one cycle, and the control pins are driven while the interface is enabled. The bench scenarios cover the end-to-end behaviour that needs a latch-and-SRAM model. These are the exact cycle at which ready arrives and the strobe length for each wait-state count, a write followed by a read back through the model, and the wait count being captured at request time. They also cover requests made during a busy access being dropped, and the pin multiplexing for partial high-bus widths with the interface both enabled and disabled.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 2,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h10FF,
  localparam int HI_W = ADDR_W - 8,
  localparam int HCW = $clog2(HI_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [HCW-1:0]    cfg_hi_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [7:0]        req_wdata,
  output logic              rdy,
  output logic              rsp_err,
  output logic [7:0]        rdata,
  output logic              int_req,
  output logic              int_we,
  input  logic [7:0]        int_rdata,
  input  logic [7:0]        ad_in,
  output logic [7:0]        pin_lo_out,
  output logic              pin_lo_oe,
  output logic [HI_W-1:0]   pin_hi_out,
  output logic [HI_W-1:0]   pin_hi_oe,
  output logic [2:0]        pin_ctl_out,
  output logic [2:0]        pin_ctl_oe,
  input  logic [7:0]        port_lo_out,
  input  logic              port_lo_oe,
  input  logic [HI_W-1:0]   port_hi_out,
  input  logic [HI_W-1:0]   port_hi_oe,
  input  logic [2:0]        port_ctl_out,
  input  logic [2:0]        port_ctl_oe
);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_ADDR, S_ALAT, S_STRB, S_POST} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q, umap_q;
  logic [7:0]        wd_q, rd_q;
  logic [WAIT_W-1:0] cnt;

  logic idle_hit, is_int;
  assign idle_hit = req && (st == S_IDLE);
  assign is_int   = (req_addr <= INT_TOP);
  assign int_req  = idle_hit && is_int;
  assign int_we   = int_req && req_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_q <= '0;
      we_q <= 1'b0;
      umap_q <= 1'b0;
      wd_q <= '0;
      rd_q <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          a_q <= req_addr;
          we_q <= req_we;
          wd_q <= req_wdata;
          cnt <= cfg_wait;
          umap_q <= !is_int && !cfg_en;
          st <= (is_int || !cfg_en) ? S_INT : S_ADDR;
        end
        S_INT:  st <= S_IDLE;
        S_ADDR: st <= S_ALAT;
        S_ALAT: st <= S_STRB;
        S_STRB: if (cnt == '0) begin
          if (!we_q) rd_q <= ad_in;
          st <= S_POST;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_POST: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic       ale_i, rd_n_i, wr_n_i, bus_oe;
  logic [7:0] bus_out;
  logic       data_ph;

  assign data_ph = (st == S_STRB) || (st == S_POST);
  assign ale_i   = (st == S_ADDR) || (st == S_INT);
  assign rd_n_i  = !((st == S_STRB) && !we_q);
  assign wr_n_i  = !((st == S_STRB) && we_q);
  assign bus_oe  = (st == S_ADDR) || (st == S_ALAT) || (st == S_INT) || (we_q && data_ph);
  assign bus_out = (we_q && data_ph) ? wd_q : a_q[7:0];

  assign rdy     = (st == S_INT) || (st == S_POST);
  assign rsp_err = (st == S_INT) && umap_q;
  assign rdata   = (st == S_INT) ? (umap_q ? 8'h00 : int_rdata) : rd_q;

  assign pin_lo_out  = cfg_en ? bus_out : port_lo_out;
  assign pin_lo_oe   = cfg_en ? bus_oe : port_lo_oe;
  assign pin_ctl_out = cfg_en ? {wr_n_i, rd_n_i, ale_i} : port_ctl_out;
  assign pin_ctl_oe  = cfg_en ? 3'b111 : port_ctl_oe;

  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    logic own;
    assign own = cfg_en && (i < int'(cfg_hi_n));
    assign pin_hi_out[i] = own ? a_q[8+i] : port_hi_out[i];
    assign pin_hi_oe[i]  = own ? 1'b1 : port_hi_oe[i];
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_i || wr_n_i);
  p_ale_low_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i || !wr_n_i) |-> !ale_i);
  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_i |-> !bus_oe);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR) |=> !ale_i && bus_oe && $stable(bus_out));
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_i) |-> bus_oe && $stable(bus_out) && rdy);
  p_int_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |=> rdy && !rsp_err && rd_n_i && wr_n_i);
  p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && !cfg_en && !is_int) |=> rdy && rsp_err && rd_n_i && wr_n_i);
  p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (pin_ctl_oe == 3'b111));

endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cfg_en = 1'b1;
  logic [1:0] cfg_wait = 2'd0;
  logic [3:0] cfg_hi_n = 4'd8;
  logic       req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, int_rdata = 8'hC3;
  logic [7:0] port_lo_out = 8'h11, port_hi_out = 8'h22, port_hi_oe = 8'hA5;
  logic       port_lo_oe = 1'b1;
  logic [2:0] port_ctl_out = 3'b111, port_ctl_oe = 3'b010;
  logic       rdy, rsp_err, int_req, int_we, pin_lo_oe;
  logic [7:0] rdata, ad_in, pin_lo_out, pin_hi_out, pin_hi_oe;
  logic [2:0] pin_ctl_out, pin_ctl_oe;

  xbus_ctrl u_xbus_ctrl (.clk, .rst_n, .cfg_en, .cfg_wait, .cfg_hi_n, .req, .req_addr,
    .req_we, .req_wdata, .rdy, .rsp_err, .rdata, .int_req, .int_we, .int_rdata, .ad_in,
    .pin_lo_out, .pin_lo_oe, .pin_hi_out, .pin_hi_oe, .pin_ctl_out, .pin_ctl_oe,
    .port_lo_out, .port_lo_oe, .port_hi_out, .port_hi_oe, .port_ctl_out, .port_ctl_oe);

  logic [7:0] mem [64];
  logic [7:0] lat = '0;
  always @(negedge pin_ctl_out[0]) lat <= pin_lo_out;
  always @(posedge pin_ctl_out[2]) if (rst_n) mem[lat[5:0]] <= pin_lo_out;
  assign ad_in = !pin_ctl_out[1] ? mem[lat[5:0]] : 8'h00;

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ext_access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                            input int w, input bit busy_poke);
    int cyc = 0, strb = 0, ales = 0, rdys = 0;
    bit seen = 0;
    cfg_wait = 2'(w);
    req = 1; req_addr = a; req_we = we; req_wdata = wd;
    @(negedge clk); req = 0;
    while (cyc < 30) begin
      cyc++;
      if (pin_ctl_out[0]) ales++;
      if (!pin_ctl_out[1] || !pin_ctl_out[2]) strb++;
      if (cyc == 1) begin
        chk(pin_ctl_out[0] && pin_lo_oe && pin_lo_out == a[7:0] && pin_hi_out == a[15:8],
            "R2 addr phase", pin_lo_out, a[7:0]);
        if (busy_poke) cfg_wait = 2'd0;
      end
      if (cyc == 2) begin
        chk(!pin_ctl_out[0] && pin_lo_oe && pin_lo_out == a[7:0], "R2 addr hold", pin_lo_out, a[7:0]);
        if (busy_poke) begin
          req = 1; req_addr = 16'h0010; req_we = 0; #1;
          chk(!int_req, "R9 busy request ignored", int_req, 0);
        end
      end
      if (cyc == 3) req = 0;
      if (cyc == 3 && we) chk(!pin_ctl_out[2] && pin_lo_oe && pin_lo_out == wd, "R4 data driven", pin_lo_out, wd);
      if (cyc == 3 && !we) chk(!pin_ctl_out[1] && !pin_lo_oe, "R3 bus released", pin_lo_oe, 0);
      if (!pin_ctl_out[1] || !pin_ctl_out[2])
        if (pin_ctl_out[0]) chk(0, "R5 ale low in strobe", 1, 0);
      if (rdy) begin
        rdys++;
        if (!seen) begin
          seen = 1;
          chk(cyc == 4 + w, we ? "R4 ready cycle" : "R3 ready cycle", cyc, 4 + w);
          chk(pin_ctl_out[2:1] == 2'b11, "R3 R4 strobes high at ready", pin_ctl_out, 3'b110);
          if (we) chk(pin_lo_oe && pin_lo_out == wd, "R4 data hold", pin_lo_out, wd);
          else chk(rdata == mem[a[5:0]], "R3 read data", rdata, mem[a[5:0]]);
        end
      end
      @(negedge clk);
    end
    chk(strb == 1 + w, busy_poke ? "R10 strobe length uses captured wait" : "R3 R4 strobe length", strb, 1 + w);
    chk(ales == 1, "R2 one ale pulse", ales, 1);
    chk(rdys == 1, "R9 single ready", rdys, 1);
  endtask

  task automatic t_reset();
    chk(pin_ctl_out == 3'b110 && !pin_lo_oe && !rdy, "R1 reset state", {pin_ctl_out, pin_lo_oe, rdy}, 5'b11000);
  endtask

  task automatic t_internal(input bit en);
    cfg_en = en;
    req = 1; req_addr = 16'h0804; req_we = 0; #1;
    chk(int_req, "R6 internal select", int_req, 1);
    @(negedge clk); req = 0;
    chk(rdy && !rsp_err && rdata == 8'hC3, "R6 internal ready data", rdata, 8'hC3);
    if (en) chk(pin_ctl_out == 3'b111 && pin_lo_oe && pin_lo_out == 8'h04, "R6 ale pulse, strobes idle",
                pin_ctl_out, 3'b111);
    else chk(pin_ctl_out == port_ctl_out, "R6 disabled pins from port", pin_ctl_out, port_ctl_out);
    @(negedge clk);
    chk(!rdy, "R6 single ready", rdy, 0);
    cfg_en = 1;
  endtask

  task automatic t_unmapped();
    int bad = 0;
    cfg_en = 0;
    req = 1; req_addr = 16'h3000; req_we = 1; #1;
    chk(!int_req, "R7 no aliasing", int_req, 0);
    @(negedge clk); req = 0;
    chk(rdy && rsp_err && rdata == 8'h00, "R7 unmapped response", {rdy, rsp_err}, 2'b11);
    for (int i = 0; i < 4; i++) begin
      if (pin_ctl_out != port_ctl_out) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 no strobe activity", bad, 0);
    cfg_en = 1;
  endtask

  task automatic t_override();
    cfg_en = 0; #1;
    chk(pin_hi_oe == port_hi_oe && pin_lo_oe == port_lo_oe && pin_lo_out == port_lo_out &&
        pin_ctl_oe == port_ctl_oe, "R8 disabled pins follow port", pin_hi_oe, port_hi_oe);
    cfg_en = 1; cfg_hi_n = 4'd4; #1;
    chk(pin_hi_oe == {port_hi_oe[7:4], 4'hF}, "R8 partial high oe", pin_hi_oe, {port_hi_oe[7:4], 4'hF});
    chk(pin_hi_out[7:4] == port_hi_out[7:4] && pin_ctl_oe == 3'b111, "R8 partial high out",
        pin_hi_out, port_hi_out);
    cfg_hi_n = 4'd8; @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    ext_access(16'h2005, 0, 8'h00, 0, 0);
    ext_access(16'h4A11, 0, 8'h00, 2, 0);
    ext_access(16'h2107, 1, 8'h3C, 1, 0);
    ext_access(16'h2107, 0, 8'h00, 3, 0);
    chk(mem[7] == 8'h3C, "R4 write reached memory", mem[7], 8'h3C);
    ext_access(16'h8020, 0, 8'h00, 2, 1);
    t_internal(1);
    t_internal(0);
    t_unmapped();
    t_override();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule